// File: doc/BRIEF.md
# Golden-Compare Mismatch Tally

This block scores a group of pattern-detecting machines under test against one fault-free golden machine. All of them are fed the same serial bit stream, and that stream comes from a stimulus generator inside this block. On every clock the block compares each tested machine's match flag with the golden flag. A disagreement counts as a missed detection when only the golden machine matched. It counts as a false detection when only the tested machine matched. Each machine has a saturating counter for each kind of disagreement in each fault category, so four counters per machine.

The generator shifts out 16-bit patterns most significant bit first. It alternates the key pattern with a near-miss copy of the key that has exactly one bit inverted. A free-running LFSR picks the inverted bit. The block also counts the key patterns it has sent, so that error rates per pattern can be computed afterwards. The `cat_dbl` input gives the fault category of the current run, single or double. A one-cycle `clr` pulse zeroes every counter. Any counter can be read through a select input and a read bus.

The stimulus stream has no back-pressure. The machines under test take one bit on every clock, so the stream offers neither valid nor ready. The markers `stim_key` and `stim_end` say which pattern is being sent and where it ends.

Top module: `mm_tally_top`

## Requirements
- R1: While reset is held and on the first cycle after it, every counter reads zero, `stim_key` is 1, `stim_end` is 0 and `stim_out` carries the first (most significant) bit of the key.
- R2: Each cycle with `gold_hit`=1 and `mut_hit[d]`=0 adds one to machine d's miss counter in the current category. The new value is readable after the next rising edge.
- R3: Each cycle with `gold_hit`=0 and `mut_hit[d]`=1 adds one to machine d's false-detection counter in the current category.
- R4: A cycle in which a machine agrees with the golden flag (both 1 or both 0) leaves that machine's counters unchanged.
- R5: `cat_dbl`=0 sends increments to the single-fault counters and `cat_dbl`=1 sends them to the double-fault counters. The counters of the other category stay unchanged.
- R6: A counter that reaches all ones (2^CNT_W-1) holds that value and does not wrap.
- R7: `clr` high at a rising edge zeroes every counter. It overrides any increment due at that same edge.
- R8: Patterns are PAT_W bits long and go out most significant bit first. `stim_end` is high on the last bit of each pattern. Key and near-miss patterns alternate. A near-miss pattern differs from the key in exactly one bit position.
- R9: On each cycle in which `stim_end`=1 and `stim_key`=1, the key-pattern counter of the current category goes up by one. The exception is a cycle with `clr` high.
- R10: `rd_sel` picks the counter shown on `rd_data`, combinationally. Index d*4 + cat*2 + kind selects machine d, with cat 0 for single and 1 for double, and kind 0 for miss and 1 for false detection. Index 4*N_MUT + cat selects the key count of category cat. Any larger index reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of every counter |
| cat_dbl | input | 1 | Fault category of the current run: 0 single, 1 double |
| gold_hit | input | 1 | Match flag of the golden machine |
| mut_hit | input | N_MUT | Match flags of the machines under test |
| rd_sel | input | SEL_W | Counter select |
| rd_data | output | CNT_W | Value of the selected counter |
| stim_out | output | 1 | Serial stimulus bit |
| stim_key | output | 1 | 1 while the key pattern is being sent |
| stim_end | output | 1 | 1 on the last bit of a pattern |

## Verification
Each counter takes exactly one register stage. A compare or key event seen before a rising edge is readable right after that edge. The read bus shows the counter as soon as `rd_sel` changes. The stimulus outputs come straight from the shift register, so they move one bit per rising edge. The bench changes inputs on falling edges and samples 1 ns after a falling edge. Each expected count therefore includes the edge just passed and nothing later. When the bench models the key count, it looks at `stim_end`/`stim_key` on each falling edge. It credits the event to the rising edge that follows.

// File: rtl/mm_tally_pkg.sv
package mm_tally_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam int KIND_MISS = 0;
  localparam int KIND_FALSE = 1;
  localparam int SLOTS_PER_MUT = 4;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction
endpackage

// File: rtl/mm_tally_sat.sv
module mm_tally_sat #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == TOP) |=> cnt == TOP);
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));
endmodule

// File: rtl/mm_tally_stim.sv
module mm_tally_stim
  import mm_tally_pkg::*;
#(
  parameter int             PAT_W = 16,
  parameter logic [PAT_W-1:0] KEY = 16'hB5C3
) (
  input  logic clk,
  input  logic rst_n,
  output logic stim_out,
  output logic stim_key,
  output logic stim_end
);
  localparam int BC_W = $clog2(PAT_W);

  logic [PAT_W-1:0]  shreg;
  logic [BC_W-1:0]   bitpos;
  logic [LFSR_W-1:0] lfsr;
  logic [PAT_W-1:0]  near_miss;

  always_comb begin
    int unsigned fi;
    fi = int'(lfsr) % PAT_W;
    near_miss = KEY ^ (PAT_W'(1) << fi);
  end

  assign stim_out = shreg[PAT_W-1];
  assign stim_end = (bitpos == BC_W'(PAT_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= KEY;
      bitpos   <= '0;
      stim_key <= 1'b1;
      lfsr     <= LFSR_SEED;
    end else begin
      lfsr <= lfsr_step(lfsr);
      if (stim_end) begin
        bitpos   <= '0;
        stim_key <= ~stim_key;
        shreg    <= stim_key ? near_miss : KEY;
      end else begin
        bitpos <= bitpos + 1'b1;
        shreg  <= shreg << 1;
      end
    end
  end

  p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stim_end |=> stim_key != $past(stim_key));
  p_one_bit_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_end && stim_key) |=> $countones(shreg ^ KEY) == 1);
  p_key_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_end && !stim_key) |=> shreg == KEY);
endmodule

// File: rtl/mm_tally_cmp.sv
module mm_tally_cmp #(
  parameter int N = 3
) (
  input  logic         gold_hit,
  input  logic [N-1:0] mut_hit,
  output logic [N-1:0] miss,
  output logic [N-1:0] fpos
);
  for (genvar d = 0; d < N; d++) begin : g_cmp
    assign miss[d] = gold_hit & ~mut_hit[d];
    assign fpos[d] = ~gold_hit & mut_hit[d];
  end
endmodule

// File: rtl/mm_tally_top.sv
module mm_tally_top
  import mm_tally_pkg::*;
#(
  parameter int               N_MUT = 3,
  parameter int               CNT_W = 24,
  parameter int               PAT_W = 16,
  parameter logic [PAT_W-1:0] KEY   = 16'hB5C3,
  localparam int              NUM_CNT = SLOTS_PER_MUT * N_MUT + 2,
  localparam int              SEL_W   = $clog2(NUM_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cat_dbl,
  input  logic             gold_hit,
  input  logic [N_MUT-1:0] mut_hit,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             stim_out,
  output logic             stim_key,
  output logic             stim_end
);
  localparam int KEY_BASE = SLOTS_PER_MUT * N_MUT;

  logic [N_MUT-1:0]   miss_v, fpos_v;
  logic [NUM_CNT-1:0] inc_v;
  logic [CNT_W-1:0]   cnt_all [NUM_CNT];

  mm_tally_stim #(.PAT_W(PAT_W), .KEY(KEY)) u_stim (
    .clk(clk), .rst_n(rst_n),
    .stim_out(stim_out), .stim_key(stim_key), .stim_end(stim_end)
  );

  mm_tally_cmp #(.N(N_MUT)) u_cmp (
    .gold_hit(gold_hit), .mut_hit(mut_hit), .miss(miss_v), .fpos(fpos_v)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cat
    localparam logic CAT = (c == 1);
    for (genvar d = 0; d < N_MUT; d++) begin : g_mut
      assign inc_v[d*SLOTS_PER_MUT + c*2 + KIND_MISS]  = (cat_dbl == CAT) & miss_v[d];
      assign inc_v[d*SLOTS_PER_MUT + c*2 + KIND_FALSE] = (cat_dbl == CAT) & fpos_v[d];
    end
    assign inc_v[KEY_BASE + c] = (cat_dbl == CAT) & stim_end & stim_key;
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_ctr
    mm_tally_sat #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_v[k]), .cnt(cnt_all[k])
    );
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_sel) < NUM_CNT) rd_data = cnt_all[rd_sel];
  end
endmodule

// File: tb/mm_tally_top_bench.sv
`timescale 1ns/1ps
module mm_tally_top_bench;
  localparam int N_MUT = 3;
  localparam int CNT_W = 8;
  localparam int PAT_W = 16;
  localparam logic [PAT_W-1:0] KEY = 16'hB5C3;
  localparam int NUM_CNT = 4 * N_MUT + 2;
  localparam int SEL_W = $clog2(NUM_CNT + 1);

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, cat_dbl = 1'b0, gold_hit = 1'b0;
  logic [N_MUT-1:0] mut_hit = '0;
  logic [SEL_W-1:0] rd_sel = '0;
  logic [CNT_W-1:0] rd_data;
  logic stim_out, stim_key, stim_end;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mm_tally_top #(.N_MUT(N_MUT), .CNT_W(CNT_W), .PAT_W(PAT_W), .KEY(KEY)) u_mm_tally_top (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cat_dbl(cat_dbl), .gold_hit(gold_hit),
    .mut_hit(mut_hit), .rd_sel(rd_sel), .rd_data(rd_data),
    .stim_out(stim_out), .stim_key(stim_key), .stim_end(stim_end)
  );

  function automatic int slot(int d, int cat, int kind);
    return d * 4 + cat * 2 + kind;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(int s, output int v);
    rd_sel = SEL_W'(s);
    #1 v = int'(rd_data);
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic drive(logic g, logic [N_MUT-1:0] m, int n);
    gold_hit = g; mut_hit = m;
    repeat (n) @(negedge clk);
    gold_hit = 1'b0; mut_hit = '0;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 stim_key", int'(stim_key), 1);
    chk("R1 stim_end", int'(stim_end), 0);
    chk("R1 stim_out", int'(stim_out), int'(KEY[PAT_W-1]));
    for (int s = 0; s < (1 << SEL_W); s++) begin
      rd(s, v);
      chk(s < NUM_CNT ? "R1 counter zero" : "R10 out of range", v, 0);
    end
  endtask

  task automatic t_miss();
    int v;
    do_clear();
    cat_dbl = 1'b0;
    drive(1'b1, 3'b101, 5);
    rd(slot(1, 0, 0), v); chk("R2 miss m1", v, 5);
    rd(slot(0, 0, 0), v); chk("R4 agree m0", v, 0);
    rd(slot(2, 0, 0), v); chk("R4 agree m2", v, 0);
    rd(slot(1, 0, 1), v); chk("R2 no false m1", v, 0);
  endtask

  task automatic t_false();
    int v;
    do_clear();
    drive(1'b0, 3'b100, 7);
    rd(slot(2, 0, 1), v); chk("R3 false m2", v, 7);
    rd(slot(2, 0, 0), v); chk("R3 no miss m2", v, 0);
    rd(slot(0, 0, 1), v); chk("R4 idle m0", v, 0);
  endtask

  task automatic t_agree();
    int v;
    do_clear();
    drive(1'b1, 3'b111, 4);
    drive(1'b0, 3'b000, 4);
    for (int d = 0; d < N_MUT; d++)
      for (int k = 0; k < 2; k++) begin
        rd(slot(d, 0, k), v); chk("R4 agreement", v, 0);
      end
  endtask

  task automatic t_category();
    int v;
    do_clear();
    drive(1'b1, 3'b000, 2);
    cat_dbl = 1'b1;
    drive(1'b1, 3'b000, 3);
    cat_dbl = 1'b0;
    rd(slot(0, 1, 0), v); chk("R5 double m0", v, 3);
    rd(slot(2, 1, 0), v); chk("R5 double m2", v, 3);
    rd(slot(1, 0, 0), v); chk("R5 single m1", v, 2);
    rd(slot(1, 1, 1), v); chk("R5 double false m1", v, 0);
  endtask

  task automatic t_saturate();
    int v;
    do_clear();
    drive(1'b0, 3'b001, 300);
    rd(slot(0, 0, 1), v); chk("R6 saturate", v, (1 << CNT_W) - 1);
    rd(slot(1, 0, 1), v); chk("R6 other idle", v, 0);
  endtask

  task automatic t_clear_priority();
    int v;
    do_clear();
    drive(1'b1, 3'b000, 4);
    gold_hit = 1'b1; clr = 1'b1;
    @(negedge clk);
    gold_hit = 1'b0; clr = 1'b0;
    rd(slot(0, 0, 0), v); chk("R7 clear wins", v, 0);
    rd(slot(2, 0, 0), v); chk("R7 clear wins m2", v, 0);
  endtask

  task automatic t_stimulus();
    logic [PAT_W-1:0] pat;
    logic first_key, prev_key;
    prev_key = 1'b0;
    while (!stim_end) @(negedge clk);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      first_key = stim_key;
      pat = '0;
      for (int b = 0; b < PAT_W; b++) begin
        pat = {pat[PAT_W-2:0], stim_out};
        if (b == PAT_W - 1) chk("R8 end marker", int'(stim_end), 1);
        else if (stim_end) chk("R8 early end", int'(stim_end), 0);
        @(negedge clk);
      end
      if (first_key) chk("R8 key pattern", int'(pat), int'(KEY));
      else chk("R8 one bit off", $countones(pat ^ KEY), 1);
      if (p > 0) chk("R8 alternation", int'(first_key != prev_key), 1);
      prev_key = first_key;
    end
  endtask

  task automatic t_keys();
    int v, e0, e1;
    do_clear();
    cat_dbl = 1'b0; e0 = 0; e1 = 0;
    for (int i = 0; i < 80; i++) begin
      if (stim_end && stim_key) e0++;
      @(negedge clk);
    end
    cat_dbl = 1'b1;
    for (int i = 0; i < 70; i++) begin
      if (stim_end && stim_key) e1++;
      @(negedge clk);
    end
    cat_dbl = 1'b0;
    rd(4 * N_MUT + 1, v); chk("R9 keys double", v, e1);
    if (stim_end && stim_key) e0++;
    rd(4 * N_MUT, v); chk("R9 keys single", v, e0);
    rd(slot(0, 0, 0), v); chk("R10 select slot", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_miss();
    t_false();
    t_agree();
    t_category();
    t_saturate();
    t_clear_priority();
    t_stimulus();
    t_keys();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule